// File: doc/BRIEF.md
# Latched Multiplexed Three-Digit Decimal Counter

This block counts pulses on an external count input. It uses a chain of decade stages, so its value runs from 000 to 999 and then wraps. A hold register sits behind each digit. While the hold input is low, the register follows the live count. While the hold input is high, it freezes the last value, so a reading can be taken while counting goes on.

The digits leave the block one at a time on a shared four-bit BCD bus. An active-low one-hot select vector names the digit that is currently on the bus. An internal divider counts periodic scan ticks and steps the selector. This suits multiplexed displays, panel meters and event counters.

The count input and the disable input are combined into one gated level, the OR of the two. The count event is the falling edge of that gated level. It is detected in the system clock domain behind a two-flop synchronizer. A single-cycle overflow pulse marks the wrap from 999 to 000, so several blocks can be chained. A synchronous master clear takes priority over counting.

Top module: `bcd_scan_counter`

## Requirements
- R1: Each falling edge of the gated level (countIn OR countDis) adds one to the decimal count. A digit goes from 9 to 0 on the same event that advances the next higher digit.
- R2: A rising edge on countIn never changes the count.
- R3: While countDis is high, toggling countIn leaves the count unchanged.
- R4: If countDis falls while countIn is low, the gated level falls, and that counts as one event.
- R5: While latchHold is high, the bus shows the held digit values and ignores count events. When latchHold is low, the bus shows the live count.
- R6: While masterClr is high, it clears all digits, the overflow output and the selector. The selector returns to the least significant digit (digitSelN = 3'b110). The hold registers are not cleared while latchHold stays high.
- R7: overflow is high for exactly one clock, in the cycle in which the count goes from 999 to 000.
- R8: digitSelN is active-low and one-hot. Bit 0 selects the least significant digit and bit 2 the most significant. The selected digit index rises 0, 1, 2, then returns to 0, moving one step every TICKS_PER_STEP scan ticks.
- R9: bcdBus carries the BCD value of the digit that digitSelN selects.
- R10: If masterClr and a count event fall in the same clock, the clear wins. The count becomes 000 and no overflow pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| masterClr | input | 1 | Synchronous master clear, active high |
| countIn | input | 1 | Asynchronous count pulse input |
| countDis | input | 1 | Count disable, ORed with countIn |
| latchHold | input | 1 | High freezes the digit hold registers |
| scanTick | input | 1 | Periodic one-cycle tick feeding the scan divider |
| bcdBus | output | 4 | BCD value of the selected digit |
| digitSelN | output | 3 | Active-low one-hot digit select |
| overflow | output | 1 | One-cycle pulse on the wrap from 999 to 000 |

## Verification
A count event and a master clear can land in the same clock. The worst case is the event that would carry 999 to 000. The bench counts the block up to 999 and then lowers countIn. Two synchronizer flops and the edge detector put the count event on the third rising edge after the input falls, and the bench raises masterClr for exactly that edge. It then judges that the display reads 000 and that the overflow pulse never appeared. The bench also checks that a later, unobstructed wrap does give one pulse.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;
  localparam int DIGIT_W = 4;

  typedef struct packed {
    logic countStep;
    logic scanStep;
    logic clear;
  } ctrlStrobes_t;
endpackage

// File: rtl/bcd_scan_ctrl.sv
module bcd_scan_ctrl
  import bcd_scan_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int TICKS_PER_STEP = 2
) (
  input  logic         clk,
  input  logic         masterClr,
  input  logic         countIn,
  input  logic         countDis,
  input  logic         scanTick,
  output ctrlStrobes_t strobes
);
  logic                   gatedLvl;
  logic [SYNC_STAGES-1:0] syncPipe;
  logic                   prevLvl;
  logic                   scanStep;

  assign gatedLvl = countIn | countDis;

  // Reset to zero: a falling edge can never appear straight out of clear.
  always_ff @(posedge clk) begin
    if (masterClr) begin
      syncPipe <= '0;
      prevLvl  <= 1'b0;
    end else begin
      syncPipe <= {syncPipe[SYNC_STAGES-2:0], gatedLvl};
      prevLvl  <= syncPipe[SYNC_STAGES-1];
    end
  end

  generate
    if (TICKS_PER_STEP == 1) begin : gDirect
      assign scanStep = scanTick;
    end else begin : gDivide
      localparam int TICK_W = $clog2(TICKS_PER_STEP);
      logic [TICK_W-1:0] tickCnt;
      logic              lastTick;
      assign lastTick = (tickCnt == TICK_W'(TICKS_PER_STEP - 1));
      assign scanStep = scanTick & lastTick;
      always_ff @(posedge clk) begin
        if (masterClr)     tickCnt <= '0;
        else if (scanTick) tickCnt <= lastTick ? '0 : tickCnt + 1'b1;
      end
    end
  endgenerate

  assign strobes.countStep = prevLvl & ~syncPipe[SYNC_STAGES-1];
  assign strobes.scanStep  = scanStep;
  assign strobes.clear     = masterClr;
endmodule

// File: rtl/bcd_scan_datapath.sv
module bcd_scan_datapath
  import bcd_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 3
) (
  input  logic                  clk,
  input  ctrlStrobes_t          strobes,
  input  logic                  latchHold,
  output logic [DIGIT_W-1:0]    bcdBus,
  output logic [NUM_DIGITS-1:0] digitSelN,
  output logic                  overflow
);
  localparam int SEL_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] liveDig;
  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] heldDig;
  logic [NUM_DIGITS:0]                carry;
  logic [SEL_W-1:0]                   selIdx;

  assign carry[0] = strobes.countStep;

  generate
    for (genvar i = 0; i < NUM_DIGITS; i++) begin : gDigit
      logic atNine;
      assign atNine     = (liveDig[i] == DIGIT_W'(9));
      assign carry[i+1] = carry[i] & atNine;

      always_ff @(posedge clk) begin
        if (strobes.clear)  liveDig[i] <= '0;
        else if (carry[i])  liveDig[i] <= atNine ? '0 : liveDig[i] + 1'b1;
      end

      // Hold register: follows the live digit, frozen while latchHold is high.
      always_ff @(posedge clk) begin
        if (!latchHold) heldDig[i] <= liveDig[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      overflow <= 1'b0;
      selIdx   <= '0;
    end else begin
      overflow <= carry[NUM_DIGITS];
      if (strobes.scanStep)
        selIdx <= (selIdx == SEL_W'(NUM_DIGITS - 1)) ? '0 : selIdx + 1'b1;
    end
  end

  always_comb begin
    digitSelN         = '1;
    digitSelN[selIdx] = 1'b0;
    bcdBus            = latchHold ? heldDig[selIdx] : liveDig[selIdx];
  end
endmodule

// File: rtl/bcd_scan_counter.sv
module bcd_scan_counter
  import bcd_scan_pkg::*;
#(
  parameter int NUM_DIGITS     = 3,
  parameter int SYNC_STAGES    = 2,
  parameter int TICKS_PER_STEP = 2
) (
  input  logic                  clk,
  input  logic                  masterClr,
  input  logic                  countIn,
  input  logic                  countDis,
  input  logic                  latchHold,
  input  logic                  scanTick,
  output logic [DIGIT_W-1:0]    bcdBus,
  output logic [NUM_DIGITS-1:0] digitSelN,
  output logic                  overflow
);
  ctrlStrobes_t strobes;

  bcd_scan_ctrl #(
    .SYNC_STAGES   (SYNC_STAGES),
    .TICKS_PER_STEP(TICKS_PER_STEP)
  ) uCtrl (
    .clk      (clk),
    .masterClr(masterClr),
    .countIn  (countIn),
    .countDis (countDis),
    .scanTick (scanTick),
    .strobes  (strobes)
  );

  bcd_scan_datapath #(
    .NUM_DIGITS(NUM_DIGITS)
  ) uData (
    .clk      (clk),
    .strobes  (strobes),
    .latchHold(latchHold),
    .bcdBus   (bcdBus),
    .digitSelN(digitSelN),
    .overflow (overflow)
  );
endmodule

// File: rtl/bcd_scan_counter_chk.sv
module bcd_scan_counter_chk #(
  parameter int NUM_DIGITS = 3
) (
  input logic                  clk,
  input logic                  masterClr,
  input logic                  latchHold,
  input logic                  scanTick,
  input logic [3:0]            bcdBus,
  input logic [NUM_DIGITS-1:0] digitSelN,
  input logic                  overflow
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (masterClr)
    $onehot(~digitSelN)); // R8

  AST_SEL_NEEDS_TICK: assert property (@(posedge clk) disable iff (masterClr)
    !scanTick |=> $stable(digitSelN)); // R8

  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (masterClr)
    overflow |=> !overflow); // R7

  AST_OVF_SHOWS_ZERO: assert property (@(posedge clk) disable iff (masterClr)
    (overflow && !latchHold) |-> (bcdBus == 4'd0)); // R7

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (masterClr)
    (latchHold && $past(latchHold) && $stable(digitSelN)) |-> $stable(bcdBus)); // R5

  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (masterClr)
    $past(masterClr) |-> (digitSelN[0] == 1'b0 && !overflow)); // R6
endmodule

bind bcd_scan_counter bcd_scan_counter_chk #(.NUM_DIGITS(NUM_DIGITS)) uChk (
  .clk      (clk),
  .masterClr(masterClr),
  .latchHold(latchHold),
  .scanTick (scanTick),
  .bcdBus   (bcdBus),
  .digitSelN(digitSelN),
  .overflow (overflow)
);

// File: tb/sim_bcd_scan_counter.sv
module sim_bcd_scan_counter;
  localparam int TICKS = 2;

  logic       clk = 1'b0;
  logic       masterClr = 1'b1;
  logic       countIn = 1'b0;
  logic       countDis = 1'b0;
  logic       latchHold = 1'b0;
  logic       scanTick = 1'b0;
  logic [3:0] bcdBus;
  logic [2:0] digitSelN;
  logic       overflow;

  int errs = 0;
  int checks = 0;
  int ovfCycles = 0;
  int cyc = 0;
  bit done = 0;

  bcd_scan_counter #(.NUM_DIGITS(3), .SYNC_STAGES(2), .TICKS_PER_STEP(TICKS)) u0 (
    .clk(clk), .masterClr(masterClr), .countIn(countIn), .countDis(countDis),
    .latchHold(latchHold), .scanTick(scanTick), .bcdBus(bcdBus),
    .digitSelN(digitSelN), .overflow(overflow)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (overflow) ovfCycles++;
    if (cyc > 150000 && !done) begin
      errs++; checks++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic scanStep();
    repeat (TICKS) begin
      scanTick = 1'b1; waitClk(1);
      scanTick = 1'b0; waitClk(1);
    end
  endtask

  // Walks the selector once around and assembles the displayed value.
  task automatic readDisplay(output int val);
    int dig[3];
    for (int k = 0; k < 3; k++) begin
      for (int p = 0; p < 3; p++) if (digitSelN[p] == 1'b0) dig[p] = int'(bcdBus);
      scanStep();
    end
    val = dig[0] + 10 * dig[1] + 100 * dig[2];
  endtask

  task automatic pulse();
    countIn = 1'b1; waitClk(4);
    countIn = 1'b0; waitClk(5);
  endtask

  initial begin
    int v;
    waitClk(10);
    masterClr = 1'b0;
    waitClk(2);
    // R6 reset state
    check(digitSelN == 3'b110, "R6 sel after clear", digitSelN, 3'b110);
    check(overflow == 1'b0, "R6 overflow after clear", overflow, 0);
    readDisplay(v); check(v == 0, "R6 count after clear", v, 0);

    // R8 selector order and divider
    scanTick = 1'b1; waitClk(1); scanTick = 1'b0; waitClk(1);
    check(digitSelN == 3'b110, "R8 single tick holds", digitSelN, 3'b110);
    scanTick = 1'b1; waitClk(1); scanTick = 1'b0; waitClk(1);
    check(digitSelN == 3'b101, "R8 step to middle", digitSelN, 3'b101);
    scanStep();
    check(digitSelN == 3'b011, "R8 step to top", digitSelN, 3'b011);
    scanStep();
    check(digitSelN == 3'b110, "R8 wrap to least", digitSelN, 3'b110);

    // R2 rising edge, R1 falling edge
    countIn = 1'b1; waitClk(6);
    readDisplay(v); check(v == 0, "R2 rising edge no count", v, 0);
    countIn = 1'b0; waitClk(5);
    readDisplay(v); check(v == 1, "R1 falling edge counts", v, 1);

    // R3 disable blocks counting, R4 disable falling counts
    countDis = 1'b1; waitClk(5);
    repeat (3) begin countIn = 1'b1; waitClk(4); countIn = 1'b0; waitClk(4); end
    readDisplay(v); check(v == 1, "R3 disabled toggles ignored", v, 1);
    countDis = 1'b0; waitClk(5);
    readDisplay(v); check(v == 2, "R4 disable release counts", v, 2);

    // R5 hold
    latchHold = 1'b1; waitClk(2);
    repeat (3) pulse();
    readDisplay(v); check(v == 2, "R5 held value shown", v, 2);
    latchHold = 1'b0; waitClk(2);
    readDisplay(v); check(v == 5, "R5 live value after release", v, 5);

    // R6 clear leaves held value
    latchHold = 1'b1; waitClk(2);
    scanStep();
    masterClr = 1'b1; waitClk(1); masterClr = 1'b0; waitClk(1);
    check(digitSelN == 3'b110, "R6 clear resets selector", digitSelN, 3'b110);
    readDisplay(v); check(v == 5, "R6 hold survives clear", v, 5);
    latchHold = 1'b0; waitClk(2);
    readDisplay(v); check(v == 0, "R6 live count cleared", v, 0);

    // R1 R9 exhaustive sweep 1..999
    for (int i = 1; i <= 999; i++) begin
      pulse();
      readDisplay(v);
      check(v == i, "R1 R9 sweep value", v, i);
    end
    check(ovfCycles == 0, "R7 no overflow below wrap", ovfCycles, 0);

    // R10 clear collides with the 999->000 event
    countIn = 1'b1; waitClk(4);
    countIn = 1'b0; waitClk(2);
    masterClr = 1'b1; waitClk(1); masterClr = 1'b0; waitClk(3);
    readDisplay(v); check(v == 0, "R10 clear wins count", v, 0);
    check(ovfCycles == 0, "R10 no overflow on collision", ovfCycles, 0);

    // R7 unobstructed wrap
    repeat (999) pulse();
    readDisplay(v); check(v == 999, "R7 reached 999", v, 999);
    pulse();
    check(ovfCycles == 1, "R7 single overflow cycle", ovfCycles, 1);
    readDisplay(v); check(v == 0, "R7 wrap to 000", v, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule